// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the control-register side of a soft-core processor's entry into an exception handler. The pipeline raises a one-cycle request carrying a cause code, a break flag and the PC of the faulting instruction. One cycle later the block commits the entry in a single clock edge. It rewrites the status register and, when no handler is already active, saves the old status and the return address. It records the cause, updates the translation-fault flag register, and emits a one-cycle redirect pulse with the handler address.

The exception-handling bit in status decides how much is saved, and whether the flags and the vector follow the first-level rules or the nested rules. A translation miss that arrives while a handler is running is treated as a double miss and sent to the general vector. A static configuration input states whether an MMU is present. Without one, the handling bit and the flag register are left alone. The processor can also load status directly, for example when returning from a handler.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset all registers read zero and `redirect` is low.
- R2: A request sampled at clock edge k commits at edge k+1. At that edge every register updates and `redirect` goes high for exactly one cycle. `redirect_pc` is the fast-miss vector (default 0x100) only for a translation miss taken with the handling bit clear, and the general vector (default 0x20) for every other entry. Requests on consecutive cycles commit on consecutive edges, in order, and the second sees the state left by the first.
- R3: The status layout is: bit 0 interrupt enable, bit 1 user mode, bit 2 handling bit (EH), bits 7:4 current register set, bits 11:8 previous register set. Every entry clears bits 0, 1 and 7:4 and leaves bits 31:12 and bit 3 unchanged.
- R4: With EH clear, the old status is saved into `bstatus_q` on a break, otherwise into `estatus_q`. The return address is saved into `ba_q` on a break, otherwise into `ea_q`. Bits 11:8 of status are loaded from the old bits 7:4.
- R5: With EH set, `estatus_q`, `bstatus_q`, `ea_q`, `ba_q` and status bits 11:8 are left unchanged.
- R6: The flag register layout is: bit 0 data side (D), bit 1 permission (PERM), bit 2 bad address (BAD), bit 3 double miss (DBL), bit 4 write enable (WE). With EH clear and `mmu_present` high, the entry sets EH, clears D, PERM, BAD and DBL, and then ORs in the cause's flags. WE is never cleared. With `mmu_present` low, neither EH nor the flags change.
- R7: Cause codes are: 0 interrupt, 1 fetch miss, 2 data miss, 3 load permission, 4 store permission, 5 fetch permission, 6 fetch supervisor address, 7 data supervisor address, 8 supervisor instruction, 9 illegal, 10 data misalign, 11 destination misalign, 12 divide, 13 trap. Other codes are taken with no flags and the general vector. `cause_q` takes the code on every entry that is not a break; a break leaves it unchanged.
- R8: A miss (codes 1 and 2) with EH clear ORs in WE, plus D for code 2, and uses the fast-miss vector.
- R9: A miss with EH set clears D, PERM and BAD, then sets DBL, plus D for code 2. It keeps WE and uses the general vector. This applies regardless of `mmu_present`.
- R10: A permission fault ORs in PERM, plus D for codes 3 and 4, plus WE when EH is clear.
- R11: Codes 6 and 11 OR in BAD. Codes 7 and 10 OR in BAD and D.
- R12: For an interrupt (code 0, break flag low), the saved return address is the request PC plus 4. For every other entry it is the request PC.
- R13: `sts_wr` loads status from `sts_wr_data` at the next edge. A load that meets a commit on the same edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_present | input | 1 | Static configuration: MMU present |
| exc_req | input | 1 | One-cycle exception request |
| exc_cause | input | 5 | Cause code of the request |
| exc_brk | input | 1 | Request is a break |
| exc_pc | input | 32 | PC of the faulting instruction |
| sts_wr | input | 1 | Direct status load strobe |
| sts_wr_data | input | 32 | Value for direct status load |
| status_q | output | 32 | Status register |
| estatus_q | output | 32 | Saved exception status |
| bstatus_q | output | 32 | Saved break status |
| cause_q | output | 5 | Exception cause register |
| tlbflags_q | output | 5 | Translation-fault flag register |
| ea_q | output | 32 | Exception return address |
| ba_q | output | 32 | Break return address |
| redirect | output | 1 | One-cycle PC redirect pulse |
| redirect_pc | output | 32 | Handler address |

## Verification
Each cause class is driven with the handling bit clear and then set, with the MMU present and absent. This separates first-level entries from nested ones, and shows when the flag and EH updates are gated by the configuration. Breaks and interrupts are compared against ordinary faults, which exposes routing to the wrong save register, cause writes on a break, and a missing +4. Back-to-back requests show whether the second entry sees the first one's status, which is what turns a second miss into a double miss. A status load that lands on the commit edge shows the priority between the two writes. Random causes, PCs, break flags and status preloads spread the register-set fields and the flag history across many values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_W = 5;
  localparam int RS_W    = 4;
  localparam int FLAG_W  = 5;

  // status bit positions
  localparam int ST_IEN  = 0;
  localparam int ST_USR  = 1;
  localparam int ST_EH   = 2;
  localparam int ST_CRS  = 4;
  localparam int ST_PRS  = ST_CRS + RS_W;
  localparam int ST_TOP  = ST_PRS + RS_W;

  // flag bit positions
  localparam int FL_D    = 0;
  localparam int FL_PERM = 1;
  localparam int FL_BAD  = 2;
  localparam int FL_DBL  = 3;
  localparam int FL_WE   = 4;

  typedef enum logic [CAUSE_W-1:0] {
    C_IRQ    = 5'd0,
    C_MISS_F = 5'd1,
    C_MISS_D = 5'd2,
    C_PERM_L = 5'd3,
    C_PERM_S = 5'd4,
    C_PERM_F = 5'd5,
    C_SUPA_F = 5'd6,
    C_SUPA_D = 5'd7,
    C_SUPI   = 5'd8,
    C_ILL    = 5'd9,
    C_MIS_D  = 5'd10,
    C_MIS_T  = 5'd11,
    C_DIV    = 5'd12,
    C_TRAP   = 5'd13
  } cause_e;

  typedef struct packed {
    logic [FLAG_W-1:0] set;
    logic              miss;
    logic              irq;
    logic              fast;
  } dec_t;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  input  logic               brk,
  input  logic               eh,
  output dec_t               dec
);
  always_comb begin
    dec = '0;
    if (!brk) begin
      case (cause)
        C_IRQ: dec.irq = 1'b1;
        C_MISS_F, C_MISS_D: begin
          dec.miss = 1'b1;
          dec.set[FL_D] = (cause == C_MISS_D);
          if (eh) begin
            dec.set[FL_DBL] = 1'b1;
          end else begin
            dec.set[FL_WE] = 1'b1;
            dec.fast       = 1'b1;
          end
        end
        C_PERM_L, C_PERM_S, C_PERM_F: begin
          dec.set[FL_PERM] = 1'b1;
          dec.set[FL_D]    = (cause != C_PERM_F);
          dec.set[FL_WE]   = !eh;
        end
        C_SUPA_F, C_MIS_T: dec.set[FL_BAD] = 1'b1;
        C_SUPA_D, C_MIS_D: begin
          dec.set[FL_BAD] = 1'b1;
          dec.set[FL_D]   = 1'b1;
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_status_next.sv
module exc_status_next
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_st,
  input  logic            mmu,
  output logic [XLEN-1:0] new_st
);
  logic eh;
  assign eh = old_st[ST_EH];

  always_comb begin
    new_st = old_st;
    if (!eh) begin
      new_st[ST_PRS +: RS_W] = old_st[ST_CRS +: RS_W];
      if (mmu) new_st[ST_EH] = 1'b1;
    end
    new_st[ST_CRS +: RS_W] = '0;
    new_st[ST_IEN]         = 1'b0;
    new_st[ST_USR]         = 1'b0;
  end
endmodule

// File: rtl/exc_flag_next.sv
module exc_flag_next
  import exc_entry_pkg::*;
(
  input  logic [FLAG_W-1:0] old_fl,
  input  dec_t              dec,
  input  logic              eh,
  input  logic              mmu,
  output logic [FLAG_W-1:0] new_fl
);
  logic [FLAG_W-1:0] clr_first, clr_dbl;

  always_comb begin
    clr_first = '0;
    clr_first[FL_D] = 1'b1; clr_first[FL_PERM] = 1'b1;
    clr_first[FL_BAD] = 1'b1; clr_first[FL_DBL] = 1'b1;
    clr_dbl = clr_first;
    clr_dbl[FL_DBL] = 1'b0;
  end

  always_comb begin
    if (!eh && mmu)        new_fl = (old_fl & ~clr_first) | dec.set;
    else if (eh && dec.miss) new_fl = (old_fl & ~clr_dbl) | dec.set;
    else                   new_fl = old_fl;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] GEN_VEC  = 32'h0000_0020,
  parameter logic [XLEN-1:0] FAST_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmu_present,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_brk,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic               sts_wr,
  input  logic [XLEN-1:0]    sts_wr_data,
  output logic [XLEN-1:0]    status_q,
  output logic [XLEN-1:0]    estatus_q,
  output logic [XLEN-1:0]    bstatus_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [FLAG_W-1:0]  tlbflags_q,
  output logic [XLEN-1:0]    ea_q,
  output logic [XLEN-1:0]    ba_q,
  output logic               redirect,
  output logic [XLEN-1:0]    redirect_pc
);
  localparam logic [XLEN-1:0] IRQ_STEP = XLEN'(4);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // request holding stage
  logic               pend_v, pend_v_d;
  logic [CAUSE_W-1:0] pend_cause, pend_cause_d;
  logic               pend_brk, pend_brk_d;
  logic [XLEN-1:0]    pend_pc, pend_pc_d;

  // commit-side combinational results
  dec_t              dec;
  logic [XLEN-1:0]   st_commit;
  logic [FLAG_W-1:0] fl_commit;
  logic              eh_now;
  logic [XLEN-1:0]   ret_addr;

  assign eh_now = status_q[ST_EH];

  exc_cause_decode u_dec (
    .cause (pend_cause),
    .brk   (pend_brk),
    .eh    (eh_now),
    .dec   (dec)
  );

  exc_status_next #(.XLEN(XLEN)) u_st (
    .old_st (status_q),
    .mmu    (mmu_present),
    .new_st (st_commit)
  );

  exc_flag_next u_fl (
    .old_fl (tlbflags_q),
    .dec    (dec),
    .eh     (eh_now),
    .mmu    (mmu_present),
    .new_fl (fl_commit)
  );

  assign ret_addr = dec.irq ? (pend_pc + IRQ_STEP) : pend_pc;

  // next-state
  logic [XLEN-1:0]    status_d, estatus_d, bstatus_d, ea_d, ba_d, rpc_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [FLAG_W-1:0]  flags_d;
  logic               redirect_d;
  logic               st_en, est_en, bst_en, ea_en, ba_en, cause_en, fl_en, rpc_en;

  always_comb begin
    pend_v_d     = exc_req;
    pend_cause_d = exc_cause;
    pend_brk_d   = exc_brk;
    pend_pc_d    = exc_pc;

    st_en    = pend_v | sts_wr;
    status_d = pend_v ? st_commit : sts_wr_data;

    est_en    = pend_v && !eh_now && !pend_brk;
    bst_en    = pend_v && !eh_now &&  pend_brk;
    estatus_d = status_q;
    bstatus_d = status_q;
    ea_en     = est_en;
    ba_en     = bst_en;
    ea_d      = ret_addr;
    ba_d      = ret_addr;

    cause_en = pend_v && !pend_brk;
    cause_d  = pend_cause;

    fl_en   = pend_v;
    flags_d = fl_commit;

    redirect_d = pend_v;
    rpc_en     = pend_v;
    rpc_d      = dec.fast ? FAST_VEC : GEN_VEC;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pend_v      <= 1'b0;
      pend_cause  <= '0;
      pend_brk    <= 1'b0;
      pend_pc     <= '0;
      status_q    <= '0;
      estatus_q   <= '0;
      bstatus_q   <= '0;
      cause_q     <= '0;
      tlbflags_q  <= '0;
      ea_q        <= '0;
      ba_q        <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      pend_v     <= pend_v_d;
      pend_cause <= pend_cause_d;
      pend_brk   <= pend_brk_d;
      pend_pc    <= pend_pc_d;
      redirect   <= redirect_d;
      if (st_en)    status_q    <= status_d;
      if (est_en)   estatus_q   <= estatus_d;
      if (bst_en)   bstatus_q   <= bstatus_d;
      if (ea_en)    ea_q        <= ea_d;
      if (ba_en)    ba_q        <= ba_d;
      if (cause_en) cause_q     <= cause_d;
      if (fl_en)    tlbflags_q  <= flags_d;
      if (rpc_en)   redirect_pc <= rpc_d;
    end
  end

  // R3
  entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_i)
    pend_v |=> (status_q[ST_CRS +: RS_W] == '0) && !status_q[ST_IEN] && !status_q[ST_USR]);

  // R2
  redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_i)
    redirect |-> $past(pend_v));

  // R5
  nested_nosave_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pend_v && status_q[ST_EH]) |=> ($stable(estatus_q) && $stable(bstatus_q) &&
                                      $stable(ea_q) && $stable(ba_q)));

  // R9
  nested_vec_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pend_v && status_q[ST_EH]) |=> (redirect_pc == GEN_VEC));

  // R6
  no_mmu_flags_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pend_v && !mmu_present && !status_q[ST_EH]) |=> ($stable(tlbflags_q) && !status_q[ST_EH]));

  // R13
  sts_load_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (sts_wr && !pend_v) |=> (status_q == $past(sts_wr_data)));
endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  localparam logic [31:0] GEN  = 32'h0000_0020;
  localparam logic [31:0] FAST = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n, mmu_present, exc_req, exc_brk, sts_wr;
  logic [4:0]  exc_cause;
  logic [31:0] exc_pc, sts_wr_data;
  logic [31:0] status_q, estatus_q, bstatus_q, ea_q, ba_q, redirect_pc;
  logic [4:0]  cause_q, tlbflags_q;
  logic        redirect;

  always #2.5 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mmu_present(mmu_present),
    .exc_req(exc_req), .exc_cause(exc_cause), .exc_brk(exc_brk), .exc_pc(exc_pc),
    .sts_wr(sts_wr), .sts_wr_data(sts_wr_data),
    .status_q(status_q), .estatus_q(estatus_q), .bstatus_q(bstatus_q),
    .cause_q(cause_q), .tlbflags_q(tlbflags_q), .ea_q(ea_q), .ba_q(ba_q),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  logic [31:0] m_st, m_est, m_bst, m_ea, m_ba, m_rpc;
  logic [4:0]  m_cause, m_fl;
  logic        m_mmu;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "status",   status_q,    m_st);
    chk(tag, "estatus",  estatus_q,   m_est);
    chk(tag, "bstatus",  bstatus_q,   m_bst);
    chk(tag, "ea",       ea_q,        m_ea);
    chk(tag, "ba",       ba_q,        m_ba);
    chk(tag, "cause",    {27'd0, cause_q},    {27'd0, m_cause});
    chk(tag, "flags",    {27'd0, tlbflags_q}, {27'd0, m_fl});
    chk(tag, "redirect", {31'd0, redirect},   32'd1);
    chk(tag, "vector",   redirect_pc, m_rpc);
  endtask

  // reference entry computed from the requirement text
  task automatic m_commit(input logic [4:0] c, input logic b, input logic [31:0] pc);
    logic eh;
    logic [4:0] add;
    logic miss, fast;
    logic [31:0] ret, ns;
    eh = m_st[2]; add = 5'd0; miss = 1'b0; fast = 1'b0;
    if (!b) begin
      if (c == 5'd1 || c == 5'd2) begin
        miss = 1'b1;
        if (c == 5'd2) add[0] = 1'b1;
        if (eh) add[3] = 1'b1; else begin add[4] = 1'b1; fast = 1'b1; end
      end else if (c >= 5'd3 && c <= 5'd5) begin
        add[1] = 1'b1;
        if (c != 5'd5) add[0] = 1'b1;
        if (!eh) add[4] = 1'b1;
      end else if (c == 5'd6 || c == 5'd11) add[2] = 1'b1;
      else if (c == 5'd7 || c == 5'd10) add = 5'b00101;
    end
    ret = (!b && c == 5'd0) ? pc + 32'd4 : pc;
    if (!eh) begin
      if (b) begin m_bst = m_st; m_ba = ret; end
      else   begin m_est = m_st; m_ea = ret; end
    end
    if (!eh && m_mmu)   m_fl = (m_fl & 5'b10000) | add;
    else if (eh && miss) m_fl = (m_fl & 5'b11000) | add;
    ns = m_st;
    if (!eh) begin
      ns[11:8] = m_st[7:4];
      if (m_mmu) ns[2] = 1'b1;
    end
    ns[7:4] = 4'd0; ns[1:0] = 2'b00;
    m_st = ns;
    if (!b) m_cause = c;
    m_rpc = fast ? FAST : GEN;
  endtask

  task automatic do_reset(input logic mmu);
    rst_n = 1'b0; mmu_present = mmu; exc_req = 1'b0; exc_brk = 1'b0;
    exc_cause = 5'd0; exc_pc = 32'd0; sts_wr = 1'b0; sts_wr_data = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_st = 0; m_est = 0; m_bst = 0; m_ea = 0; m_ba = 0; m_rpc = 0;
    m_cause = 0; m_fl = 0; m_mmu = mmu;
  endtask

  task automatic do_exc(input string tag, input logic [4:0] c, input logic b, input logic [31:0] pc);
    @(negedge clk);
    exc_req = 1'b1; exc_cause = c; exc_brk = b; exc_pc = pc;
    @(negedge clk);
    exc_req = 1'b0;
    @(negedge clk);
    m_commit(c, b, pc);
    check_all(tag);
    @(negedge clk);
    chk("R2", "pulse end", {31'd0, redirect}, 32'd0);
  endtask

  task automatic do_stw(input logic [31:0] v);
    @(negedge clk);
    sts_wr = 1'b1; sts_wr_data = v;
    @(negedge clk);
    sts_wr = 1'b0;
    m_st = v;
    chk("R13", "status load", status_q, v);
  endtask

  function automatic string tag_of(input logic [4:0] c, input logic b);
    if (b) return "R4";
    if (c == 5'd0) return "R12";
    if (c == 5'd1 || c == 5'd2) return (m_st[2] ? "R9" : "R8");
    if (c >= 5'd3 && c <= 5'd5) return "R10";
    if (c == 5'd6 || c == 5'd7 || c == 5'd10 || c == 5'd11) return "R11";
    return "R7";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    // R1 reset state
    do_reset(1'b1);
    chk("R1", "status",   status_q,    32'd0);
    chk("R1", "estatus",  estatus_q,   32'd0);
    chk("R1", "flags",    {27'd0, tlbflags_q}, 32'd0);
    chk("R1", "ea",       ea_q,        32'd0);
    chk("R1", "redirect", {31'd0, redirect}, 32'd0);

    // R8 first-level data miss, then R9 nested miss via R5 path
    do_stw(32'h8000_0053);               // CRS=5, IEN, USR set
    do_exc("R8", 5'd2, 1'b0, 32'h0000_1000);
    do_exc("R9", 5'd1, 1'b0, 32'h0000_2000);
    do_exc("R5", 5'd9, 1'b0, 32'h0000_3000);
    do_exc("R5", 5'd0, 1'b1, 32'h0000_4000);

    // R10 permission with EH clear then set
    do_reset(1'b1);
    do_exc("R10", 5'd4, 1'b0, 32'h0000_0500);
    do_exc("R10", 5'd3, 1'b0, 32'h0000_0600);
    // R11 bad address variants
    do_reset(1'b1);
    do_exc("R11", 5'd10, 1'b0, 32'h0000_0700);
    do_reset(1'b1);
    do_exc("R11", 5'd6, 1'b0, 32'h0000_0704);
    // R12 interrupt return address, R4/R7 break routing
    do_reset(1'b0);
    do_exc("R12", 5'd0, 1'b0, 32'h0000_0800);
    do_exc("R7", 5'd13, 1'b0, 32'h0000_0900);
    do_exc("R4", 5'd13, 1'b1, 32'h0000_0a00);
    // R6 no MMU: EH and flags stay
    do_exc("R6", 5'd2, 1'b0, 32'h0000_0b00);

    // R2 back-to-back: second sees first (double miss)
    do_reset(1'b1);
    @(negedge clk);
    exc_req = 1'b1; exc_cause = 5'd1; exc_brk = 1'b0; exc_pc = 32'h0000_c000;
    @(negedge clk);
    exc_cause = 5'd2; exc_pc = 32'h0000_c004;
    @(negedge clk);
    exc_req = 1'b0;
    m_commit(5'd1, 1'b0, 32'h0000_c000);
    check_all("R2");
    @(negedge clk);
    m_commit(5'd2, 1'b0, 32'h0000_c004);
    check_all("R9");
    @(negedge clk);
    chk("R2", "pulse end", {31'd0, redirect}, 32'd0);

    // R13 status load colliding with a commit is dropped
    do_reset(1'b1);
    @(negedge clk);
    exc_req = 1'b1; exc_cause = 5'd12; exc_brk = 1'b0; exc_pc = 32'h0000_d000;
    @(negedge clk);
    exc_req = 1'b0; sts_wr = 1'b1; sts_wr_data = 32'hffff_ffff;
    @(negedge clk);
    sts_wr = 1'b0;
    m_commit(5'd12, 1'b0, 32'h0000_d000);
    check_all("R13");

    // random mix
    for (int seg = 0; seg < 12; seg++) begin
      do_reset(1'($urandom_range(0, 1)));
      for (int i = 0; i < 30; i++) begin
        if ($urandom_range(0, 5) == 0) begin
          logic [31:0] v;
          v = $urandom;
          if ($urandom_range(0, 1) == 1) v[2] = 1'b0;
          do_stw(v);
        end else begin
          logic [4:0] c;
          logic b;
          c = 5'($urandom_range(0, 15));
          b = ($urandom_range(0, 7) == 0);
          do_exc(tag_of(c, b), c, b, $urandom & 32'hffff_fffc);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule